// File: doc/BRIEF.md
# DMA Transfer Width Sequencer

This block turns one buffer burst of a DMA engine into a sequence of bus beats. Each beat is either 8 or 16 bits wide. Software-side logic loads a start address and a byte count and then starts the sequencer. The sequencer asks for one beat at a time with a request/acknowledge pair. For each beat it presents the address, a word/byte flag and the byte lanes in use.

The width of each beat is worked out from several inputs. These are the parity of the current address, the bytes still owed by the buffer, the bytes the FIFO reports as available, and the room left in the current bus ownership. A mode input forces every beat to a single byte. One ownership never moves more than `BURST_MAX` bytes, which is 16 by default. When that cap stops a buffer partway, the sequencer raises `pause_o` and keeps its address and count. A later start without a load then continues where it stopped. A start with a load begins a fresh buffer.

Each burst serves one channel in one direction only. Bus arbitration, address latching and the FIFO data are handled outside this block.

Top module: `dws_top`

## Requirements
- R1: A beat is a word (`beat_word_o`=1) exactly when all of the following hold: the address is even, at least 2 buffer bytes remain, the FIFO reports at least 2 bytes, at least 2 bytes of ownership room remain, and `byte_only_i` is low. Otherwise the beat is a byte.
- R2: A buffer with an even start and an odd count is sent as words, followed by one final byte beat.
- R3: A buffer with an odd start sends one byte beat first and then continues in words. Only the boundary beats are bytes.
- R4: While `byte_only_i` is high, every beat is a byte, whatever the alignment.
- R5: One ownership moves at most `BURST_MAX` bytes. When the cap is reached with bytes still owed, `pause_o` rises. A start with `load_i`=0 then continues from the retained address and count, with fresh room. If a word would overrun the cap, a byte beat is issued instead.
- R6: A zero byte count raises `done_o` without issuing any beat.
- R7: No beat is requested while the FIFO reports 0 bytes. With 1 byte available, the beat is a byte even at an even address.
- R8: The address advances by 1 after an acknowledged byte beat and by 2 after an acknowledged word beat. It holds while a request is not acknowledged.
- R9: The lane encoding is as follows. Bit 0 is the even-address byte and bit 1 is the odd-address byte. A word beat uses 2'b11. A byte beat uses 2'b01 at an even address and 2'b10 at an odd address.
- R10: After reset, `beat_req_o`, `done_o`, `pause_o` and `busy_o` are low.
- R11: `done_o` rises once the buffer is exhausted, even if this happens exactly at the cap, and it is never raised together with `pause_o`. `done_o` holds until the next accepted start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously inside |
| start_i | input | 1 | Start an ownership; accepted only while idle |
| load_i | input | 1 | With start: 1 loads a new buffer, 0 resumes the retained one |
| start_addr_i | input | ADDR_W | Buffer start address |
| byte_cnt_i | input | CNT_W | Buffer length in bytes |
| byte_only_i | input | 1 | Force all beats to 8 bits |
| fifo_avail_i | input | AVAIL_W | Bytes the FIFO can supply or accept now |
| beat_ack_i | input | 1 | Beat accepted this cycle |
| beat_req_o | output | 1 | A beat is being requested |
| beat_addr_o | output | ADDR_W | Address of the requested beat |
| beat_word_o | output | 1 | 1: 16-bit beat, 0: 8-bit beat |
| beat_lane_o | output | 2 | Byte lanes of the beat |
| busy_o | output | 1 | An ownership is in progress |
| done_o | output | 1 | Buffer finished |
| pause_o | output | 1 | Ownership cap reached with bytes left |

## Verification
The bench targets four edges of the width choice. An odd start followed by an even tail checks that both boundary beats are bytes. A design that lost the parity check would emit an unaligned word. An odd run that hits the cap with a single byte of room left must issue a byte and then pause. A design that let a word through would move 17 bytes in one ownership. A buffer of exactly the cap length must finish with `done_o` rather than `pause_o`. Stalled acknowledges and a FIFO that reports 0 and then 1 byte show whether the address steps only on accepted beats. They also show whether the FIFO level is respected at an even address. A zero-length buffer must end with no request at all.

// File: rtl/dws_pkg.sv
package dws_pkg;
  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_RUN  = 1'b1
  } dws_state_e;

  localparam logic [1:0] LANE_EVEN = 2'b01;
  localparam logic [1:0] LANE_ODD  = 2'b10;
  localparam logic [1:0] LANE_BOTH = 2'b11;
endpackage

// File: rtl/dws_rst_sync.sv
module dws_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_ni,
  output logic rst_no
);
  logic [STAGES-1:0] chain_q;
  logic [STAGES-1:0] chain_d;

  generate
    if (STAGES == 1) begin : g_single
      assign chain_d = 1'b1;
    end else begin : g_multi
      assign chain_d = {chain_q[STAGES-2:0], 1'b1};
    end
  endgenerate

  always_ff @(posedge clk or negedge arst_ni) begin
    if (!arst_ni) chain_q <= '0;
    else          chain_q <= chain_d;
  end

  assign rst_no = chain_q[STAGES-1];
endmodule

// File: rtl/dws_width_pick.sv
module dws_width_pick
  import dws_pkg::*;
#(
  parameter int CNT_W   = 16,
  parameter int AVAIL_W = 5,
  parameter int ROOM_W  = 5
) (
  input  logic               run_i,
  input  logic               addr_lsb_i,
  input  logic [CNT_W-1:0]   rem_i,
  input  logic [AVAIL_W-1:0] avail_i,
  input  logic [ROOM_W-1:0]  room_i,
  input  logic               byte_only_i,
  output logic               go_o,
  output logic               word_o,
  output logic [1:0]         lane_o
);
  logic rem_two, avail_two, room_two;

  always_comb begin
    rem_two   = rem_i   > CNT_W'(1);
    avail_two = avail_i > AVAIL_W'(1);
    room_two  = room_i  > ROOM_W'(1);
    go_o      = run_i && (rem_i != '0) && (avail_i != '0) && (room_i != '0);
    word_o    = !byte_only_i && !addr_lsb_i && rem_two && avail_two && room_two;
    if (word_o)          lane_o = LANE_BOTH;
    else if (addr_lsb_i) lane_o = LANE_ODD;
    else                 lane_o = LANE_EVEN;
  end
endmodule

// File: rtl/dws_track.sv
module dws_track #(
  parameter int ADDR_W    = 32,
  parameter int CNT_W     = 16,
  parameter int BURST_MAX = 16,
  parameter int ROOM_W    = 5
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              accept_i,
  input  logic              load_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [CNT_W-1:0]  byte_cnt_i,
  input  logic              fire_i,
  input  logic              word_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [CNT_W-1:0]  rem_o,
  output logic [ROOM_W-1:0] room_o
);
  logic [ADDR_W-1:0] addr_q, addr_d;
  logic [CNT_W-1:0]  rem_q, rem_d;
  logic [ROOM_W-1:0] room_q, room_d;
  logic              buf_en, room_en;

  always_comb begin
    buf_en  = (accept_i && load_i) || fire_i;
    room_en = accept_i || fire_i;
    addr_d  = addr_q;
    rem_d   = rem_q;
    room_d  = room_q;
    if (accept_i) begin
      room_d = ROOM_W'(BURST_MAX);
      if (load_i) begin
        addr_d = start_addr_i;
        rem_d  = byte_cnt_i;
      end
    end else if (fire_i) begin
      addr_d = addr_q + (word_i ? ADDR_W'(2) : ADDR_W'(1));
      rem_d  = rem_q  - (word_i ? CNT_W'(2)  : CNT_W'(1));
      room_d = room_q - (word_i ? ROOM_W'(2) : ROOM_W'(1));
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      addr_q <= '0;
      rem_q  <= '0;
    end else if (buf_en) begin
      addr_q <= addr_d;
      rem_q  <= rem_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       room_q <= '0;
    else if (room_en) room_q <= room_d;
  end

  assign addr_o = addr_q;
  assign rem_o  = rem_q;
  assign room_o = room_q;
endmodule

// File: rtl/dws_ctrl.sv
module dws_ctrl
  import dws_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic start_i,
  input  logic rem_zero_i,
  input  logic cap_hit_i,
  output logic run_o,
  output logic accept_o,
  output logic done_o,
  output logic pause_o
);
  dws_state_e state_q, state_d;
  logic done_q, done_d, pause_q, pause_d;

  always_comb begin
    state_d  = state_q;
    done_d   = done_q;
    pause_d  = pause_q;
    accept_o = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (start_i) begin
          accept_o = 1'b1;
          state_d  = ST_RUN;
          done_d   = 1'b0;
          pause_d  = 1'b0;
        end
      end
      ST_RUN: begin
        if (rem_zero_i) begin
          state_d = ST_IDLE;
          done_d  = 1'b1;
        end else if (cap_hit_i) begin
          state_d = ST_IDLE;
          pause_d = 1'b1;
        end
      end
      default: state_d = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
      pause_q <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
      pause_q <= pause_d;
    end
  end

  assign run_o   = (state_q == ST_RUN);
  assign done_o  = done_q;
  assign pause_o = pause_q;
endmodule

// File: rtl/dws_top.sv
module dws_top #(
  parameter int ADDR_W      = 32,
  parameter int CNT_W       = 16,
  parameter int BURST_MAX   = 16,
  parameter int SYNC_STAGES = 2,
  localparam int AVAIL_W    = $clog2(BURST_MAX + 1),
  localparam int ROOM_W     = $clog2(BURST_MAX + 1)
) (
  input  logic               clk,
  input  logic               rst_ni,
  input  logic               start_i,
  input  logic               load_i,
  input  logic [ADDR_W-1:0]  start_addr_i,
  input  logic [CNT_W-1:0]   byte_cnt_i,
  input  logic               byte_only_i,
  input  logic [AVAIL_W-1:0] fifo_avail_i,
  input  logic               beat_ack_i,
  output logic               beat_req_o,
  output logic [ADDR_W-1:0]  beat_addr_o,
  output logic               beat_word_o,
  output logic [1:0]         beat_lane_o,
  output logic               busy_o,
  output logic               done_o,
  output logic               pause_o
);
  logic              rst_n;
  logic              run, accept, go, word, fire;
  logic [ADDR_W-1:0] addr;
  logic [CNT_W-1:0]  rem;
  logic [ROOM_W-1:0] room;

  dws_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk(clk), .arst_ni(rst_ni), .rst_no(rst_n)
  );

  dws_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start_i(start_i),
    .rem_zero_i(rem == '0), .cap_hit_i(room == '0),
    .run_o(run), .accept_o(accept), .done_o(done_o), .pause_o(pause_o)
  );

  dws_width_pick #(.CNT_W(CNT_W), .AVAIL_W(AVAIL_W), .ROOM_W(ROOM_W)) u_pick (
    .run_i(run), .addr_lsb_i(addr[0]), .rem_i(rem), .avail_i(fifo_avail_i),
    .room_i(room), .byte_only_i(byte_only_i),
    .go_o(go), .word_o(word), .lane_o(beat_lane_o)
  );

  assign fire = go && beat_ack_i;

  dws_track #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .BURST_MAX(BURST_MAX), .ROOM_W(ROOM_W)) u_track (
    .clk(clk), .rst_n(rst_n), .accept_i(accept), .load_i(load_i),
    .start_addr_i(start_addr_i), .byte_cnt_i(byte_cnt_i),
    .fire_i(fire), .word_i(word),
    .addr_o(addr), .rem_o(rem), .room_o(room)
  );

  assign beat_req_o  = go;
  assign beat_addr_o = addr;
  assign beat_word_o = word;
  assign busy_o      = run;
endmodule

// File: rtl/dws_checker.sv
module dws_checker #(
  parameter int ADDR_W    = 32,
  parameter int BURST_MAX = 16,
  parameter int AVAIL_W   = 5
) (
  input logic               clk,
  input logic               rst_ni,
  input logic               start_i,
  input logic               byte_only_i,
  input logic [AVAIL_W-1:0] fifo_avail_i,
  input logic               beat_ack_i,
  input logic               beat_req_o,
  input logic [ADDR_W-1:0]  beat_addr_o,
  input logic               beat_word_o,
  input logic [1:0]         beat_lane_o,
  input logic               busy_o,
  input logic               done_o,
  input logic               pause_o
);
  localparam int MOV_W = $clog2(BURST_MAX + 3);
  logic [MOV_W-1:0] moved_q;

  always_ff @(posedge clk or negedge rst_ni) begin
    if (!rst_ni)                      moved_q <= '0;
    else if (start_i && !busy_o)      moved_q <= '0;
    else if (beat_req_o && beat_ack_i)
      moved_q <= moved_q + (beat_word_o ? MOV_W'(2) : MOV_W'(1));
  end

  // R1
  word_even_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    beat_req_o && beat_word_o |-> !beat_addr_o[0]);
  // R4
  byte_only_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    beat_req_o && byte_only_i |-> !beat_word_o);
  // R7
  fifo_level_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    beat_req_o |-> (fifo_avail_i != '0) && (!beat_word_o || fifo_avail_i > AVAIL_W'(1)));
  // R8
  addr_step_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    beat_req_o && beat_ack_i |=> !beat_req_o ||
      (beat_addr_o == $past(beat_addr_o) + ($past(beat_word_o) ? ADDR_W'(2) : ADDR_W'(1))));
  // R9
  lane_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    beat_req_o |-> (beat_word_o ? (beat_lane_o == 2'b11)
                                : ($countones(beat_lane_o) == 1 && beat_lane_o[1] == beat_addr_o[0])));
  // R5
  burst_cap_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    moved_q <= MOV_W'(BURST_MAX));
  // R11
  done_pause_excl_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    !(done_o && pause_o));
  // R10
  req_in_busy_chk: assert property (@(posedge clk) disable iff (!rst_ni)
    beat_req_o |-> busy_o);
endmodule

bind dws_top dws_checker #(.ADDR_W(ADDR_W), .BURST_MAX(BURST_MAX), .AVAIL_W(AVAIL_W)) chk_i (
  .clk(clk), .rst_ni(rst_ni), .start_i(start_i), .byte_only_i(byte_only_i),
  .fifo_avail_i(fifo_avail_i), .beat_ack_i(beat_ack_i), .beat_req_o(beat_req_o),
  .beat_addr_o(beat_addr_o), .beat_word_o(beat_word_o), .beat_lane_o(beat_lane_o),
  .busy_o(busy_o), .done_o(done_o), .pause_o(pause_o)
);

// File: tb/dws_top_tb_top.sv
module dws_top_tb_top;
  localparam int ADDR_W = 32;
  localparam int CNT_W  = 16;
  localparam int BMAX   = 16;
  localparam int AW     = $clog2(BMAX + 1);

  logic              clk = 1'b0;
  logic              rst_ni = 1'b0;
  logic              start_i = 1'b0, load_i = 1'b0, byte_only_i = 1'b0, beat_ack_i = 1'b0;
  logic [ADDR_W-1:0] start_addr_i = '0;
  logic [CNT_W-1:0]  byte_cnt_i = '0;
  logic [AW-1:0]     fifo_avail_i = '0;
  logic              beat_req_o, beat_word_o, busy_o, done_o, pause_o;
  logic [ADDR_W-1:0] beat_addr_o;
  logic [1:0]        beat_lane_o;

  int n_chk = 0, n_fail = 0, cyc = 0;
  int m_addr, m_rem, m_room;

  always #4 clk = ~clk;

  dws_top dut_i (.*);

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic finish_run();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
      finish_run();
    end
  end

  // One ownership: start, serve beats against the model, check the ending.
  task automatic run(input int a0, input int cnt, input bit bo, input bit ld,
                     input int av_a, input int av_b, input int av_sw, input bit ack_alt,
                     input string tag, output int beats);
    int sz, av;
    bit exp_req, exp_word;
    logic [1:0] exp_lane;
    beats = 0;
    @(negedge clk);
    start_i = 1'b1; load_i = ld; start_addr_i = a0; byte_cnt_i = cnt; byte_only_i = bo;
    if (ld) begin m_addr = a0; m_rem = cnt; end
    m_room = BMAX;
    @(negedge clk);
    start_i = 1'b0;
    for (int c = 0; c < 200; c++) begin
      av = (c < av_sw) ? av_a : av_b;
      fifo_avail_i = AW'(av);
      beat_ack_i = ack_alt ? c[0] : 1'b1;
      #1;
      if (done_o || pause_o) break;
      exp_req  = (m_rem > 0) && (m_room > 0) && (av > 0);
      exp_word = !bo && !m_addr[0] && m_rem >= 2 && av >= 2 && m_room >= 2;
      exp_lane = exp_word ? 2'b11 : (m_addr[0] ? 2'b10 : 2'b01);
      if (beat_req_o !== exp_req) chk(0, {tag, " req"}, beat_req_o, exp_req);
      if (exp_req) begin
        chk(beat_addr_o == ADDR_W'(m_addr) && beat_word_o == exp_word && beat_lane_o == exp_lane,
            {tag, " beat R8 R9"}, {beat_addr_o, beat_word_o, beat_lane_o},
            {ADDR_W'(m_addr), exp_word, exp_lane});
        if (beat_ack_i) begin
          sz = exp_word ? 2 : 1;
          m_addr += sz; m_rem -= sz; m_room -= sz; beats++;
        end
      end
      @(negedge clk);
    end
    beat_ack_i = 1'b0;
    chk(done_o == (m_rem == 0) && pause_o == (m_rem != 0), {tag, " end R11 R5"},
        {done_o, pause_o}, {m_rem == 0, m_rem != 0});
  endtask

  task automatic t_reset();
    #1;
    chk(!beat_req_o && !done_o && !pause_o && !busy_o, "R10 reset", {beat_req_o, done_o, pause_o, busy_o}, 0);
  endtask

  task automatic t_aligned();
    int b;
    run(32'h100, 8, 0, 1, 16, 16, 0, 0, "R1 aligned", b);
    chk(b == 4, "R1 beat count", b, 4);
  endtask

  task automatic t_odd_count();
    int b;
    run(32'h200, 7, 0, 1, 16, 16, 0, 0, "R2 even-odd", b);
    chk(b == 4, "R2 beat count", b, 4);
  endtask

  task automatic t_odd_start();
    int b;
    run(32'h101, 6, 0, 1, 16, 16, 0, 0, "R3 odd start", b);
    chk(b == 4, "R3 beat count", b, 4);
  endtask

  task automatic t_byte_only();
    int b;
    run(32'h300, 5, 1, 1, 16, 16, 0, 0, "R4 byte only", b);
    chk(b == 5, "R4 beat count", b, 5);
  endtask

  task automatic t_cap_resume();
    int b;
    run(32'h400, 40, 0, 1, 16, 16, 0, 0, "R5 cap 1", b);
    chk(b == 8 && pause_o, "R5 first pause", b, 8);
    run(0, 0, 0, 0, 16, 16, 0, 0, "R5 resume", b);
    chk(beat_addr_o == 32'h420 && b == 8, "R5 retained addr", beat_addr_o, 32'h420);
    run(0, 0, 0, 0, 16, 16, 0, 0, "R5 tail", b);
    chk(b == 4 && done_o, "R5 tail count", b, 4);
  endtask

  task automatic t_cap_odd();
    int b;
    run(32'h501, 20, 0, 1, 16, 16, 0, 0, "R5 odd cap", b);
    chk(b == 9 && pause_o, "R5 byte at cap edge", b, 9);
    run(0, 0, 0, 0, 16, 16, 0, 0, "R5 odd resume", b);
    chk(b == 3 && done_o, "R5 odd resume count", b, 3);
  endtask

  task automatic t_zero();
    int b;
    run(32'h600, 0, 0, 1, 16, 16, 0, 0, "R6 zero", b);
    chk(b == 0 && done_o, "R6 no beats", b, 0);
  endtask

  task automatic t_fifo();
    int b;
    run(32'h700, 4, 0, 1, 0, 1, 5, 0, "R7 fifo", b);
    chk(b == 4, "R7 byte beats on low fifo", b, 4);
  endtask

  task automatic t_stall();
    int b;
    run(32'h801, 6, 0, 1, 16, 16, 0, 1, "R8 stall", b);
    chk(b == 4, "R8 beat count", b, 4);
  endtask

  task automatic t_exact_cap();
    int b;
    run(32'h900, 16, 0, 1, 16, 16, 0, 0, "R11 exact", b);
    chk(done_o && !pause_o, "R11 done at cap", {done_o, pause_o}, 2'b10);
    repeat (5) @(negedge clk);
    chk(done_o && !beat_req_o, "R11 done held", {done_o, beat_req_o}, 2'b10);
  endtask

  initial begin
    t_reset();
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    repeat (4) @(negedge clk);
    t_reset();
    t_aligned();
    t_odd_count();
    t_odd_start();
    t_byte_only();
    t_cap_resume();
    t_cap_odd();
    t_zero();
    t_fifo();
    t_stall();
    t_exact_cap();
    finish_run();
  end
endmodule